// File: doc/BRIEF.md
# Serial ADC Readout Controller

This block is the master side of a three-wire serial link to a 12-bit successive-approximation converter. It drives the serial clock and an active-low chip select, and it receives the converter's data line. A one-cycle `start` pulse, taken while the block is idle, lowers chip select. The block then issues sixteen serial clocks, grouped as two 8-bit segments, and shifts in one bit on every rising serial clock edge. After the last clock it raises chip select again, which puts the converter into shutdown. It then presents the 12-bit result together with a one-cycle `done` strobe.

The sixteen received bits arrive in this order: two bits with no defined value, a zero null bit, the result from bit 11 down to bit 0, and one bit of the converter's LSB-first repeat. The block recovers the result by shifting the capture right by one place and keeping its low twelve bits. The serial clock period is `DIV` system clocks, and `DIV` must be even. The default of 8 turns an 8 MHz system clock into a 1 MHz serial clock. The serial clock must stay at or above 10 kHz. The `idle_high` input selects the clock's resting level and is read only while reset is asserted: 1 selects idle-high operation (mode 1,1) and 0 selects idle-low operation (mode 0,0).

Top module: `sar_adc_reader`

## Requirements
- R1: After reset and whenever `cs_n` is high, `busy` and `done` are low and `sclk` sits at the idle level: 1 if `idle_high` was 1 during reset, 0 otherwise. `result` resets to 0.
- R2: `idle_high` is latched only while `rst_n` is low. Changing it after reset has no effect on the idle level of `sclk`.
- R3: A `start` sampled high while idle lowers `cs_n` and raises `busy` at that same clock edge. `busy` equals the inverse of `cs_n` at all times.
- R4: Each conversion has exactly 16 rising `sclk` edges, spaced `DIV` system clocks apart. With H = `DIV`/2, the first rising edge comes H cycles after `cs_n` falls in idle-low mode and 2H cycles after it in idle-high mode.
- R5: `sdi` is sampled on rising `sclk` edges, first received bit first.
- R6: Number the received bits s0 (first) to s15 (last). The result is s3..s14, with s3 as bit 11. This equals the 16-bit capture (s0 in bit 15) shifted right by one, with the upper four bits cleared.
- R7: 33·H cycles after `cs_n` falls, `cs_n` rises and `busy` falls. At that same edge `done` is high for exactly one cycle and `result` takes the new value.
- R8: A `start` pulse that arrives while `busy` is high is ignored: `cs_n` stays low and the timing and result of the running conversion are unchanged.
- R9: `result` changes only together with `done` and holds its value between conversions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| idle_high | input | 1 | Serial clock idle level; read only during reset |
| start | input | 1 | Conversion request pulse |
| sdi | input | 1 | Serial data from the converter |
| sclk | output | 1 | Serial clock to the converter |
| cs_n | output | 1 | Active-low chip select |
| busy | output | 1 | High while a conversion is under way |
| done | output | 1 | One-cycle strobe when `result` updates |
| result | output | 12 | Last 12-bit conversion result |

## Verification
Every result is timed from the edge that accepts `start`, with H being half the serial period. `cs_n` and `busy` change at that edge. The first rising `sclk` comes H or 2H cycles later, depending on mode, and later rising edges follow every `DIV` cycles. `done`, the new `result` and the release of `cs_n` all come 33·H cycles after the accepting edge. The bench samples on falling system-clock edges and counts an offset from the accepting edge, so each expected event is compared against its exact offset rather than waited for. A converter model in the bench moves its output only after falling serial edges, so the expected result for each swept code follows from the bit-order rule alone.

// File: rtl/sar_rd_pkg.sv
package sar_rd_pkg;
  localparam int unsigned FRAME_BITS = 16;
  localparam int unsigned RES_BITS   = 12;
  localparam int unsigned HALVES     = 2 * FRAME_BITS + 1;

  // Recover the conversion value from a full 16-bit capture (first bit in MSB).
  function automatic logic [RES_BITS-1:0] take_result(input logic [FRAME_BITS-1:0] cap);
    logic [FRAME_BITS-1:0] shifted;
    shifted = cap >> 1;
    return shifted[RES_BITS-1:0];
  endfunction

  // Serial clock level for a half period: odd halves are away from idle.
  function automatic logic half_level(input logic idle, input logic odd_half);
    return idle ^ odd_half;
  endfunction
endpackage

// File: rtl/sar_rd_divider.sv
module sar_rd_divider #(
  parameter int unsigned HALF = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  generate
    if (HALF == 1) begin : g_nodiv
      assign tick = run;
    end else begin : g_div
      localparam int unsigned CW = $clog2(HALF);
      localparam logic [CW-1:0] TOP = CW'(HALF - 1);
      logic [CW-1:0] cnt;
      assign tick = run && (cnt == TOP);
      always_ff @(posedge clk) begin
        if (!rst_n || !run || tick) cnt <= '0;
        else                        cnt <= cnt + 1'b1;
      end
    end
  endgenerate
endmodule

// File: rtl/sar_rd_seq.sv
module sar_rd_seq
  import sar_rd_pkg::*;
#(
  parameter int unsigned NHALF = HALVES
) (
  input  logic clk,
  input  logic rst_n,
  input  logic idle_lvl,
  input  logic start,
  input  logic tick,
  output logic busy,
  output logic cs_n,
  output logic sclk,
  output logic samp,
  output logic fin
);
  localparam int unsigned HW = $clog2(NHALF + 1);
  localparam logic [HW-1:0] LAST = HW'(NHALF - 1);

  logic [HW-1:0] hidx;
  logic [HW-1:0] hnext;
  logic          lvl_next;
  logic          at_last;

  assign hnext    = hidx + 1'b1;
  assign at_last  = (hidx == LAST);
  assign lvl_next = half_level(idle_lvl, hnext[0]);
  assign fin      = busy && tick && at_last;
  assign samp     = busy && tick && !at_last && lvl_next && !sclk;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cs_n <= 1'b1;
      sclk <= idle_lvl;
      hidx <= '0;
    end else if (!busy) begin
      sclk <= idle_lvl;
      hidx <= '0;
      if (start) begin
        busy <= 1'b1;
        cs_n <= 1'b0;
      end
    end else if (tick) begin
      if (at_last) begin
        busy <= 1'b0;
        cs_n <= 1'b1;
        sclk <= idle_lvl;
        hidx <= '0;
      end else begin
        hidx <= hnext;
        sclk <= lvl_next;
      end
    end
  end
endmodule

// File: rtl/sar_rd_capture.sv
module sar_rd_capture
  import sar_rd_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                samp,
  input  logic                sdi,
  input  logic                fin,
  output logic [RES_BITS-1:0] result,
  output logic                done
);
  logic [FRAME_BITS-1:0] cap;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cap    <= '0;
      result <= '0;
      done   <= 1'b0;
    end else begin
      done <= fin;
      if (samp) cap <= {cap[FRAME_BITS-2:0], sdi};
      if (fin)  result <= take_result(cap);
    end
  end
endmodule

// File: rtl/sar_adc_reader.sv
module sar_adc_reader
  import sar_rd_pkg::*;
#(
  parameter int unsigned DIV = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                idle_high,
  input  logic                start,
  input  logic                sdi,
  output logic                sclk,
  output logic                cs_n,
  output logic                busy,
  output logic                done,
  output logic [RES_BITS-1:0] result
);
  localparam int unsigned HALF = DIV / 2;

  logic mode_q;   // latched idle level
  logic tick_w;   // end of a half period
  logic samp_w;   // shift in sdi at this edge (rising sclk)
  logic fin_w;    // last half period ends at this edge

  always_ff @(posedge clk) begin
    if (!rst_n) mode_q <= idle_high;
  end

  sar_rd_divider #(.HALF(HALF)) u_div (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (busy),
    .tick (tick_w)
  );

  sar_rd_seq #(.NHALF(HALVES)) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .idle_lvl(mode_q),
    .start   (start),
    .tick    (tick_w),
    .busy    (busy),
    .cs_n    (cs_n),
    .sclk    (sclk),
    .samp    (samp_w),
    .fin     (fin_w)
  );

  sar_rd_capture u_cap (
    .clk   (clk),
    .rst_n (rst_n),
    .samp  (samp_w),
    .sdi   (sdi),
    .fin   (fin_w),
    .result(result),
    .done  (done)
  );
endmodule

// File: rtl/sar_adc_reader_chk.sv
module sar_adc_reader_chk
  import sar_rd_pkg::*;
(
  input logic                clk,
  input logic                rst_n,
  input logic                start,
  input logic                cs_n,
  input logic                sclk,
  input logic                busy,
  input logic                done,
  input logic [RES_BITS-1:0] result,
  input logic                mode_q,
  input logic                fin_w
);
  logic       sclk_d;
  logic [5:0] rise_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sclk_d   <= mode_q;
      rise_cnt <= '0;
    end else begin
      sclk_d <= sclk;
      if (cs_n)               rise_cnt <= '0;
      else if (sclk && !sclk_d) rise_cnt <= rise_cnt + 1'b1;
    end
  end

  assert_idle_level_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> (sclk == mode_q));
  assert_mode_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(mode_q));
  assert_busy_select_R3: assert property (@(posedge clk) disable iff (!rst_n)
    busy == !cs_n);
  assert_start_taken_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start) |=> (busy && !cs_n));
  assert_rise_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (rise_cnt == 6'd16));
  assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (cs_n && !busy));
  assert_busy_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !fin_w) |=> (busy && !cs_n));
  assert_result_on_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(result) |-> done);
endmodule

bind sar_adc_reader sar_adc_reader_chk u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .start (start),
  .cs_n  (cs_n),
  .sclk  (sclk),
  .busy  (busy),
  .done  (done),
  .result(result),
  .mode_q(mode_q),
  .fin_w (fin_w)
);

// File: tb/sar_adc_reader_bench.sv
module sar_adc_reader_bench;
  localparam int DIV_B  = 4;
  localparam int HALF_B = DIV_B / 2;
  localparam int FIN_AT = 33 * HALF_B;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic idle_high = 1'b1;
  logic start = 1'b0;
  logic sdi = 1'b0;
  logic sclk, cs_n, busy, done;
  logic [11:0] result;

  int total = 0;
  int bad = 0;

  logic [15:0] stream = '0;
  int   rcnt = 0;
  int   idx = 0;
  logic sclk_prev = 1'b1;

  always #10 clk = ~clk;

  sar_adc_reader #(.DIV(DIV_B)) u_sar_adc_reader (
    .clk(clk), .rst_n(rst_n), .idle_high(idle_high), .start(start), .sdi(sdi),
    .sclk(sclk), .cs_n(cs_n), .busy(busy), .done(done), .result(result)
  );

  // Converter model: bit k is presented after the falling sclk that follows rising edge k.
  always @(posedge clk) begin
    #1;
    if (cs_n) begin
      rcnt = 0;
      idx  = 0;
    end else begin
      if (sclk && !sclk_prev) rcnt = rcnt + 1;
      if (!sclk && sclk_prev) idx = rcnt;
    end
    sclk_prev = sclk;
    sdi = (idx < 16) ? stream[4'(15 - idx)] : 1'b0;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic mode);
    rst_n = 1'b0;
    idle_high = mode;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cs_n && !busy && !done, "R1 idle outputs", {cs_n, busy, done}, 3'b100);
    chk(sclk == mode, "R1 idle level", sclk, mode);
    chk(result == 12'd0, "R1 result reset", result, 0);
    idle_high = ~mode;
    repeat (3) @(negedge clk);
    chk(sclk == mode, "R2 mode change ignored", sclk, mode);
  endtask

  task automatic run_conv(input logic [11:0] v, input logic mode, input bit poke);
    int rises, first, last, done_at, done_n, per_bad, stray;
    logic prev;
    logic [1:0] u;
    u = v[3:2] ^ 2'b01;
    stream = {u, 1'b0, v, v[1]};
    rises = 0; first = -1; last = -1; done_at = -1; done_n = 0; per_bad = 0; stray = 0;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    chk(!cs_n && busy, "R3 select on start", {cs_n, busy}, 2'b01);
    prev = sclk;
    for (int k = 1; k <= FIN_AT + 2; k++) begin
      start = (poke && (k == FIN_AT / 2 || k == 5)) ? 1'b1 : 1'b0;
      @(negedge clk);
      if (sclk && !prev) begin
        rises++;
        if (first < 0) first = k;
        else if (k - last != DIV_B) per_bad++;
        last = k;
      end
      prev = sclk;
      if (done) begin
        done_n++;
        if (done_at < 0) done_at = k;
      end
      if (k < FIN_AT && cs_n) stray++;
    end
    start = 1'b0;
    chk(first == (mode ? 2 * HALF_B : HALF_B), "R4 first rise offset", first, mode ? 2 * HALF_B : HALF_B);
    chk(rises == 16, "R4 rise count", rises, 16);
    chk(per_bad == 0, "R4 rise spacing", per_bad, 0);
    chk(done_at == FIN_AT, "R7 done offset", done_at, FIN_AT);
    chk(done_n == 1, "R7 done width", done_n, 1);
    chk(result == v, "R5 R6 result value", result, v);
    chk(cs_n && !busy && sclk == mode, "R7 R1 released", {cs_n, busy, sclk}, {2'b10, mode});
    if (poke) chk(stray == 0, "R8 start while busy", stray, 0);
    repeat (3) @(negedge clk);
    chk(result == v, "R9 result holds", result, v);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    do_reset(1'b1);
    run_conv(12'h000, 1'b1, 1'b0);
    run_conv(12'hFFF, 1'b1, 1'b1);
    run_conv(12'h800, 1'b1, 1'b0);
    run_conv(12'h001, 1'b1, 1'b1);
    run_conv(12'h555, 1'b1, 1'b0);
    for (int v = 0; v < 4096; v += 7) run_conv(12'(v), 1'b1, (v % 5) == 0);
    do_reset(1'b0);
    run_conv(12'hAAA, 1'b0, 1'b1);
    run_conv(12'hFFF, 1'b0, 1'b0);
    run_conv(12'h000, 1'b0, 1'b1);
    run_conv(12'h7FE, 1'b0, 1'b0);
    for (int v = 3; v < 4096; v += 11) run_conv(12'(v), 1'b0, (v % 3) == 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule